// File: doc/BRIEF.md
# Sequential-Access Buffer RAM Port

This block gives a host processor byte-wide access to a 2048-byte buffer RAM through three I/O registers. Two of them hold an 11-bit address pointer. The third is a data window. After the host loads the pointer, it can stream through consecutive RAM locations by accessing the data window over and over, without writing the address again. The RAM is split into eight 256-byte pages, and the top three pointer bits select the page. Page crossings need no special handling.

Reads are served from a prefetched data register, so the RAM read latency is hidden from the host. The prefetch starts when the pointer is loaded in read mode, and again after every auto-incrementing data read. Writes go first into a holding register and are then copied to RAM at the pointer address. While a prefetch or a write-back is in progress, a busy flag is raised, and the port ignores every host access.

The RAM is a single-port synchronous memory outside the block. When a read is enabled, its data appears one clock later. A write enable stores the data on the same clock edge.

Top module: `ram_ptr_port`

## Requirements
- R1: After reset the pointer is 0, read mode and auto-increment are off, and the prefetched data is 0. Busy is low, and reads of the pointer-high, pointer-low and data offsets all return 0.
- R2: The offsets are fixed: pointer high at 2, pointer low at 3, data at 4. A read of offset 0, 1, 5, 6 or 7 returns 0, and a write to any of these offsets changes no state.
- R3: The pointer-high layout is bit 7 = read mode, bit 6 = auto-increment, bits 2..0 = address bits 10..8. Bits 5..3 read back as 0.
- R4: Writing either pointer register while read mode is on (bit 7 of the pointer-high byte being written, or the stored mode for a pointer-low write) starts a prefetch. The RAM read enable is asserted, with the new address, in the cycle after the write. Busy stays high for exactly two cycles. The next data read then returns the RAM byte at the new pointer.
- R5: A write to the data offset latches the byte. In the next cycle the block drives the RAM write enable, with that byte and the pointer as address. Busy is high for exactly that one cycle.
- R6: When auto-increment is on, each accepted data read or data write advances the pointer by one. When it is off, the pointer does not change, and repeated data reads return the same byte.
- R7: An auto-incrementing data read in read mode prefetches the byte at the next address. Successive data reads therefore return successive RAM bytes.
- R8: While busy is high, every host read or write strobe is ignored. A pointer, data or holding-register write made during busy has no effect.
- R9: Loading the pointer with read mode off issues no RAM read, and busy stays low.
- R10: The pointer wraps from 2047 to 0, and it moves across 256-byte page boundaries with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_addr | input | 3 | Host register offset |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational from offset |
| hst_busy | output | 1 | Prefetch or write-back in progress |
| ram_addr | output | 11 | RAM address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after ram_re |

## Verification
The RAM is preloaded with a byte pattern that depends on both the page and the offset. An auto-incrementing read sweep covers all 2048 locations. This would catch a wrong page bit, a missed increment or a stale prefetch, because any of these returns a neighbouring byte. A second sweep writes a different pattern over the whole RAM and reads it back, which separates write-back addressing from prefetch addressing. Further short sequences cover the following cases:
- auto-increment turned off;
- a pointer load in write mode;
- a load at address 2047, to check the wrap;
- strobes issued during busy;
- the exact busy length of each operation.

// File: rtl/ram_ptr_port.sv
module ram_ptr_port #(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int OFS_HI   = 2,
  parameter int OFS_LO   = 3,
  parameter int OFS_DATA = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    hst_addr,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  output logic          hst_busy,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam int HB = AW - 8;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CAPT, S_WBACK} st_t;

  st_t           st_q;
  logic [AW-1:0] ptr_q;
  logic          rdmode_q, ainc_q;
  logic [DW-1:0] pre_q, hold_q;

  assign hst_busy = (st_q != S_IDLE);

  wire sel_hi  = hst_addr == 3'(OFS_HI);
  wire sel_lo  = hst_addr == 3'(OFS_LO);
  wire sel_dat = hst_addr == 3'(OFS_DATA);

  wire wr_hi  = hst_wr && sel_hi  && !hst_busy;
  wire wr_lo  = hst_wr && sel_lo  && !hst_busy;
  wire wr_dat = hst_wr && sel_dat && !hst_busy;
  wire rd_dat = hst_rd && !hst_wr && sel_dat && !hst_busy;

  wire [AW-1:0] ptr_inc = ptr_q + AW'(1);

  always_comb begin
    hst_rdata = '0;
    if (sel_hi)       hst_rdata = {rdmode_q, ainc_q, (DW-2-HB)'(0), ptr_q[AW-1:8]};
    else if (sel_lo)  hst_rdata = ptr_q[7:0];
    else if (sel_dat) hst_rdata = pre_q;
  end

  assign ram_addr  = ptr_q;
  assign ram_re    = (st_q == S_FETCH);
  assign ram_we    = (st_q == S_WBACK);
  assign ram_wdata = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ptr_q    <= '0;
      rdmode_q <= 1'b0;
      ainc_q   <= 1'b0;
      pre_q    <= '0;
      hold_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (wr_hi) begin
            ptr_q[AW-1:8] <= hst_wdata[HB-1:0];
            rdmode_q      <= hst_wdata[7];
            ainc_q        <= hst_wdata[6];
            if (hst_wdata[7]) st_q <= S_FETCH;
          end else if (wr_lo) begin
            ptr_q[7:0] <= hst_wdata;
            if (rdmode_q) st_q <= S_FETCH;
          end else if (wr_dat) begin
            hold_q <= hst_wdata;
            st_q   <= S_WBACK;
          end else if (rd_dat && ainc_q) begin
            ptr_q <= ptr_inc;
            if (rdmode_q) st_q <= S_FETCH;
          end
        end
        S_FETCH: st_q <= S_CAPT;
        S_CAPT: begin
          pre_q <= ram_rdata;
          st_q  <= S_IDLE;
        end
        S_WBACK: begin
          if (ainc_q) ptr_q <= ptr_inc;
          st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assert_prefetch_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && rdmode_q) |=> (ram_re && ram_addr[7:0] == $past(hst_wdata)));

  assert_fetch_holds_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> hst_busy);

  assert_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dat |=> (ram_we && ram_wdata == $past(hst_wdata) && ram_addr == $past(ptr_q)));

  assert_read_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dat && ainc_q) |=> (ptr_q == $past(ptr_inc)));

  assert_busy_ignores_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_busy && hst_wr && sel_dat) |=> $stable(hold_q));

  assert_no_fetch_in_write_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !rdmode_q) |=> (!ram_re && !hst_busy));
endmodule

// File: tb/ram_ptr_port_tb.sv
module ram_ptr_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hst_addr = '0;
  logic hst_rd = 1'b0, hst_wr = 1'b0;
  logic [7:0] hst_wdata = '0;
  logic [7:0] hst_rdata;
  logic hst_busy;
  logic [10:0] ram_addr;
  logic ram_re, ram_we;
  logic [7:0] ram_wdata;
  logic [7:0] ram_rdata = '0;

  int total = 0, bad = 0;
  int re_cnt = 0;
  logic [7:0] mem [2048];
  logic [7:0] expv [2048];

  always #10 clk = ~clk;

  ram_ptr_port u_dut (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_busy(hst_busy),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) begin
      ram_rdata <= mem[ram_addr];
      re_cnt <= re_cnt + 1;
    end
  end

  function automatic logic [7:0] pat_a(int a);
    return 8'((a * 7) + ((a >> 8) * 13) + 5);
  endfunction
  function automatic logic [7:0] pat_b(int a);
    return 8'((a * 3) ^ ((a >> 8) * 29) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (hst_busy) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_rd = 1'b1;
    #8 d = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  initial begin : watchdog
    #3000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int rc0;
    for (int i = 0; i < 2048; i++) begin mem[i] = pat_a(i); expv[i] = pat_a(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(hst_busy == 1'b0, "R1 busy", hst_busy, 0);
    bus_rd(3'd2, v); chk(v == 8'h00, "R1 ptr high", v, 0);
    bus_rd(3'd3, v); chk(v == 8'h00, "R1 ptr low", v, 0);
    bus_rd(3'd4, v); chk(v == 8'h00, "R1 data", v, 0);

    // R2 unused offsets read 0 and writes do nothing
    for (int o = 0; o < 8; o++) begin
      if (o >= 2 && o <= 4) continue;
      bus_wr(3'(o), 8'hFF);
      chk(hst_busy == 1'b0, "R2 no busy", hst_busy, 0);
      bus_rd(3'(o), v); chk(v == 8'h00, "R2 unused read", v, 0);
    end
    bus_rd(3'd2, v); chk(v == 8'h00, "R2 ptr high untouched", v, 0);
    bus_rd(3'd3, v); chk(v == 8'h00, "R2 ptr low untouched", v, 0);

    // R3 layout: write 0xFF to high (read mode, ainc, page 7)
    bus_wr(3'd2, 8'hFF); wait_idle();
    bus_rd(3'd2, v); chk(v == 8'hC7, "R3 ptr high readback", v, 8'hC7);

    // R4 busy length and prefetch
    bus_wr(3'd2, 8'hC1);
    chk(hst_busy == 1'b1, "R4 busy cycle 1", hst_busy, 1);
    @(negedge clk); chk(hst_busy == 1'b1, "R4 busy cycle 2", hst_busy, 1);
    @(negedge clk); chk(hst_busy == 1'b0, "R4 busy cleared", hst_busy, 0);
    bus_wr(3'd3, 8'h23); wait_idle();
    bus_rd(3'd4, v); chk(v == expv[11'h123], "R4 first read after load", v, expv[11'h123]);
    wait_idle();

    // R7/R6/R10 full read sweep from 0
    bus_wr(3'd2, 8'hC0); wait_idle();
    bus_wr(3'd3, 8'h00); wait_idle();
    for (int i = 0; i < 2048; i++) begin
      bus_rd(3'd4, v); wait_idle();
      chk(v == expv[i], "R7 read sweep", v, expv[i]);
    end
    bus_rd(3'd3, v); chk(v == 8'h00, "R10 wrap low", v, 0);
    bus_rd(3'd2, v); chk(v == 8'hC0, "R10 wrap high", v, 8'hC0);

    // R10 explicit wrap from 2047
    bus_wr(3'd2, 8'hC7); wait_idle();
    bus_wr(3'd3, 8'hFF); wait_idle();
    bus_rd(3'd4, v); wait_idle(); chk(v == expv[2047], "R10 last byte", v, expv[2047]);
    bus_rd(3'd4, v); wait_idle(); chk(v == expv[0], "R10 wrapped byte", v, expv[0]);

    // R9 write-mode load: no RAM read, no busy
    rc0 = re_cnt;
    bus_wr(3'd2, 8'h40);
    chk(hst_busy == 1'b0, "R9 busy after high", hst_busy, 0);
    bus_wr(3'd3, 8'h00);
    chk(hst_busy == 1'b0, "R9 busy after low", hst_busy, 0);
    @(negedge clk); chk(re_cnt == rc0, "R9 no RAM read", re_cnt, rc0);

    // R5/R6 full write sweep with auto-increment
    for (int i = 0; i < 2048; i++) begin
      bus_wr(3'd4, pat_b(i));
      if (i == 0) chk(hst_busy == 1'b1, "R5 busy during write-back", hst_busy, 1);
      @(negedge clk);
      if (i == 0) chk(hst_busy == 1'b0, "R5 busy one cycle", hst_busy, 0);
      wait_idle();
      expv[i] = pat_b(i);
    end
    for (int i = 0; i < 2048; i += 97)
      chk(mem[i] == expv[i], "R5 RAM content", mem[i], expv[i]);
    bus_rd(3'd3, v); chk(v == 8'h00, "R6 write wrap", v, 0);

    // readback of written pattern
    bus_wr(3'd2, 8'hC0); wait_idle();
    bus_wr(3'd3, 8'h00); wait_idle();
    for (int i = 0; i < 2048; i++) begin
      bus_rd(3'd4, v); wait_idle();
      chk(v == expv[i], "R7 readback sweep", v, expv[i]);
    end

    // R6 auto-increment off: pointer and data hold
    bus_wr(3'd2, 8'h83); wait_idle();
    bus_wr(3'd3, 8'h10); wait_idle();
    bus_rd(3'd4, v); wait_idle(); chk(v == expv[11'h310], "R6 no-inc read 1", v, expv[11'h310]);
    bus_rd(3'd4, v); wait_idle(); chk(v == expv[11'h310], "R6 no-inc read 2", v, expv[11'h310]);
    bus_rd(3'd3, v); chk(v == 8'h10, "R6 pointer held", v, 8'h10);
    bus_wr(3'd4, 8'h5A); wait_idle(); expv[11'h310] = 8'h5A;
    bus_rd(3'd3, v); chk(v == 8'h10, "R6 pointer held after write", v, 8'h10);
    chk(mem[11'h310] == 8'h5A, "R5 no-inc write", mem[11'h310], 8'h5A);

    // R8 strobes during busy are ignored
    bus_wr(3'd2, 8'hC2); wait_idle();
    @(negedge clk);
    hst_addr = 3'd3; hst_wdata = 8'h44; hst_wr = 1'b1;
    @(negedge clk);
    hst_wdata = 8'h99;
    @(negedge clk);
    hst_addr = 3'd4; hst_wdata = 8'h77;
    @(negedge clk);
    hst_wr = 1'b0;
    chk(hst_busy == 1'b0, "R8 idle after ignored writes", hst_busy, 0);
    bus_rd(3'd3, v); chk(v == 8'h44, "R8 ptr low kept", v, 8'h44);
    chk(mem[11'h244] == expv[11'h244], "R8 RAM untouched", mem[11'h244], expv[11'h244]);
    bus_rd(3'd4, v); wait_idle(); chk(v == expv[11'h244], "R8 data prefetch intact", v, expv[11'h244]);
    bus_rd(3'd3, v); chk(v == 8'h45, "R8 single advance", v, 8'h45);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule